// File: doc/BRIEF.md
# Self-Selecting Slave-Side Bus Arbiter

This block decides which of N bus masters owns one slave port of a multi-layer bus matrix. The decision is taken at the slave side: a master starts a burst and then waits on the slave's ready, so a grant covers a number of accepted transfers rather than a single request/acknowledge pair. Each arbitration point combines one of three ordering policies with one of three hold granularities. The policies are lowest index wins, rotating, and highest reported level. The granularities are one transfer, one transaction, or a master-requested transfer count. That gives nine schemes.

Software, or a wrapper, can pin the scheme through `policy_i` and `gran_i`. With `auto_i` high the block derives the scheme itself from what the requesting masters report: their priority levels and their desired burst lengths. The scheme is latched at the arbitration point and held until the next one. The grant is registered and is presented both as a one-hot vector and as an index, which the surrounding matrix uses to steer its address and data multiplexers.

Top module: `arb_slave_sel`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `grant_idx_o` is 0 and `grant_o` is 1. The rotating pointer restarts, so the first rotating decision after reset searches from master 0 upward.
- R2: `grant_o` is always one-hot with its set bit at `grant_idx_o`. A new grant appears in the cycle after the arbitration point that chose it.
- R3: Policy code 0 (and code 3) grants the lowest-indexed requesting master.
- R4: Policy code 1 grants the first requester found searching upward, with wrap, from one past the master granted last.
- R5: Policy code 2 grants the requester with the largest `level_i` field, where master i's field is bits [i*LW +: LW]. Ties go to the first tied requester in rotating order from one past the master granted last.
- R6: A beat is a cycle with `ready_i` high while the owner's 2-bit transfer type (bits [2i+1:2i] of `trans_i`) is 2 (first transfer of a burst) or 3 (continuing transfer). Granularity code 0 (and code 3) re-arbitrates on every beat.
- R7: Granularity code 1 holds the owner until, after at least one beat, the owner presents type 0 (idle) or type 2 with `ready_i` high. Type 1 (busy) and type 3 do not end the hold.
- R8: Granularity code 2 loads a counter at grant time from the winner's `len_i` field, bits [i*CW +: CW], with a value of 0 treated as 1. The grant is re-arbitrated on the beat that uses up that count.
- R9: When the owner drops its request, arbitration happens in that cycle, whatever the hold state.
- R10: With `auto_i` high, the policy is the highest-level one (R5) if the requesting masters report different levels, and the rotating one (R4) otherwise. `policy_i` is then ignored.
- R11: With `auto_i` high, the granularity is the count-based one (R8) if any requesting master reports a nonzero length, and the transaction one (R7) otherwise. `gran_i` is then ignored.
- R12: The granularity is sampled only at arbitration points. A change of `gran_i` during a hold does not alter how that hold ends.
- R13: When no master requests at an arbitration point, the grant stays parked on the last owner.
- R14: A cycle with `ready_i` low is never a beat and never ends a hold by R6, R7 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Per-master request |
| trans_i | input | 2*N | Per-master transfer type, 2 bits each |
| level_i | input | N*LW | Per-master priority level |
| len_i | input | N*CW | Per-master desired transfer count |
| ready_i | input | 1 | Slave ready for the current transfer |
| auto_i | input | 1 | Derive the scheme from the masters' reports |
| policy_i | input | 2 | Manual policy: 0 fixed, 1 rotating, 2 level, 3 fixed |
| gran_i | input | 2 | Manual granularity: 0 transfer, 1 transaction, 2 count, 3 transfer |
| grant_o | output | N | One-hot grant |
| grant_idx_o | output | $clog2(N) | Index of the granted master |

## Verification
A corrupted rotating pointer only shows up at the next contested arbitration point. There it selects the wrong master, and the error appears in `grant_idx_o` one cycle later. A wrong latched granularity or a miscounted length shows up as a grant switching one or more beats too early or too late. A lost "first beat seen" flag ends a transaction on its opening transfer. The stimulus therefore uses contested requests with rotating histories, bursts with busy, idle and stalled cycles, and mode changes made in the middle of a hold. It compares the index and the one-hot vector after every clock.

// File: rtl/arb_sel_pkg.sv
package arb_sel_pkg;

  typedef enum logic [1:0] {
    POL_FIXED = 2'd0,
    POL_RR    = 2'd1,
    POL_DYN   = 2'd2
  } pol_e;

  typedef enum logic [1:0] {
    GR_XFER  = 2'd0,
    GR_TRANS = 2'd1,
    GR_LEN   = 2'd2
  } gran_e;

  localparam logic [1:0] HT_IDLE   = 2'd0;
  localparam logic [1:0] HT_BUSY   = 2'd1;
  localparam logic [1:0] HT_NONSEQ = 2'd2;
  localparam logic [1:0] HT_SEQ    = 2'd3;

  function automatic pol_e decode_pol(input logic [1:0] code);
    case (code)
      2'd1:    return POL_RR;
      2'd2:    return POL_DYN;
      default: return POL_FIXED;
    endcase
  endfunction

  function automatic gran_e decode_gran(input logic [1:0] code);
    case (code)
      2'd1:    return GR_TRANS;
      2'd2:    return GR_LEN;
      default: return GR_XFER;
    endcase
  endfunction

endpackage

// File: rtl/arb_mode_sel.sv
module arb_mode_sel
  import arb_sel_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned LW = 2,
  parameter int unsigned CW = 4
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*LW-1:0] level_i,
  input  logic [N*CW-1:0] len_i,
  input  logic            auto_i,
  input  logic [1:0]      policy_i,
  input  logic [1:0]      gran_i,
  output pol_e            pol_o,
  output gran_e           gran_o
);

  logic          seen;
  logic          differ;
  logic          any_len;
  logic [LW-1:0] ref_lvl;

  always_comb begin
    seen    = 1'b0;
    differ  = 1'b0;
    any_len = 1'b0;
    ref_lvl = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i]) begin
        if (!seen) begin
          seen    = 1'b1;
          ref_lvl = level_i[i*LW +: LW];
        end else if (level_i[i*LW +: LW] != ref_lvl) begin
          differ = 1'b1;
        end
        if (len_i[i*CW +: CW] != '0) any_len = 1'b1;
      end
    end
  end

  always_comb begin
    if (auto_i) begin
      pol_o  = differ  ? POL_DYN : POL_RR;
      gran_o = any_len ? GR_LEN  : GR_TRANS;
    end else begin
      pol_o  = decode_pol(policy_i);
      gran_o = decode_gran(gran_i);
    end
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_sel_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned LW = 2,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  input  logic [N*LW-1:0] level_i,
  input  logic [IW-1:0]   start_i,
  input  pol_e            pol_i,
  output logic            any_o,
  output logic [IW-1:0]   win_o
);

  logic [LW-1:0] max_lvl;
  logic [N-1:0]  elig;
  logic [IW-1:0] st;

  always_comb begin
    max_lvl = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i] && level_i[i*LW +: LW] > max_lvl) max_lvl = level_i[i*LW +: LW];
    end
  end

  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      elig[i] = req_i[i] && ((pol_i != POL_DYN) || (level_i[i*LW +: LW] == max_lvl));
    end
    st = (pol_i == POL_FIXED) ? '0 : start_i;
  end

  // Single rotating scan serves all three policies
  always_comb begin
    int j;
    any_o = 1'b0;
    win_o = '0;
    for (int k = 0; k < int'(N); k++) begin
      j = int'(st) + k;
      if (j >= int'(N)) j = j - int'(N);
      if (!any_o && elig[j]) begin
        any_o = 1'b1;
        win_o = IW'(j);
      end
    end
  end

  AST_WIN_REQUESTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> req_i[win_o]); // R2
  AST_FIXED_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_o && pol_i == POL_FIXED) |-> ((req_i & ((N'(1) << win_o) - N'(1))) == '0)); // R3
  AST_NONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> !any_o); // R13

endmodule

// File: rtl/arb_hold.sv
module arb_hold
  import arb_sel_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          locked_i,
  input  logic [1:0]    own_trans_i,
  input  logic          ready_i,
  input  logic          load_i,
  input  gran_e         gran_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);

  gran_e         gran_q;
  logic [CW-1:0] cnt_q;
  logic          started_q;
  logic          beat;
  logic          trans_end;

  assign beat      = ready_i && (own_trans_i == HT_NONSEQ || own_trans_i == HT_SEQ);
  assign trans_end = started_q && ready_i && (own_trans_i == HT_IDLE || own_trans_i == HT_NONSEQ);

  always_comb begin
    done_o = 1'b0;
    if (locked_i) begin
      case (gran_q)
        GR_TRANS: done_o = trans_end;
        GR_LEN:   done_o = beat && (cnt_q == CW'(1));
        default:  done_o = beat;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gran_q    <= GR_XFER;
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (load_i) begin
      gran_q    <= gran_i;
      cnt_q     <= (len_i == '0) ? CW'(1) : len_i;
      started_q <= 1'b0;
    end else if (locked_i && beat) begin
      started_q <= 1'b1;
      if (cnt_q > CW'(1)) cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && gran_q == GR_LEN) |-> (cnt_q != '0)); // R8
  AST_END_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_i); // R14
  AST_TRANS_NEEDS_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && gran_q == GR_TRANS && !started_q) |-> !done_o); // R7
  AST_GRAN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(gran_q)); // R12

endmodule

// File: rtl/arb_slave_sel.sv
module arb_slave_sel
  import arb_sel_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned LW = 2,
  parameter int unsigned CW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  input  logic [2*N-1:0]  trans_i,
  input  logic [N*LW-1:0] level_i,
  input  logic [N*CW-1:0] len_i,
  input  logic            ready_i,
  input  logic            auto_i,
  input  logic [1:0]      policy_i,
  input  logic [1:0]      gran_i,
  output logic [N-1:0]    grant_o,
  output logic [IW-1:0]   grant_idx_o
);

  logic [IW-1:0] owner_q;
  logic [IW-1:0] ptr_q;
  logic          locked_q;
  logic          owner_req;
  logic          hold_done;
  logic          arb_pt;
  logic          any_req;
  logic [IW-1:0] win;
  logic [CW-1:0] win_len;
  logic [1:0]    own_trans;
  pol_e          pol;
  gran_e         gran;

  arb_mode_sel #(.N(N), .LW(LW), .CW(CW)) u_mode (
    .req_i    (req_i),
    .level_i  (level_i),
    .len_i    (len_i),
    .auto_i   (auto_i),
    .policy_i (policy_i),
    .gran_i   (gran_i),
    .pol_o    (pol),
    .gran_o   (gran)
  );

  arb_pick #(.N(N), .LW(LW)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .level_i (level_i),
    .start_i (ptr_q),
    .pol_i   (pol),
    .any_o   (any_req),
    .win_o   (win)
  );

  always_comb begin
    win_len   = '0;
    own_trans = HT_IDLE;
    owner_req = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (win == IW'(i))     win_len   = len_i[i*CW +: CW];
      if (owner_q == IW'(i)) begin
        own_trans = trans_i[2*i +: 2];
        owner_req = req_i[i];
      end
    end
  end

  assign arb_pt = !locked_q || !owner_req || hold_done;

  arb_hold #(.CW(CW)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .locked_i    (locked_q),
    .own_trans_i (own_trans),
    .ready_i     (ready_i),
    .load_i      (arb_pt && any_req),
    .gran_i      (gran),
    .len_i       (win_len),
    .done_o      (hold_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= '0;
      ptr_q    <= '0;
      locked_q <= 1'b0;
    end else if (arb_pt) begin
      if (any_req) begin
        owner_q  <= win;
        locked_q <= 1'b1;
        ptr_q    <= (win == IW'(N-1)) ? '0 : win + IW'(1);
      end else begin
        locked_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < int'(N); g++) begin : g_grant
    assign grant_o[g] = (owner_q == IW'(g));
  end
  assign grant_idx_o = owner_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(grant_o)); // R2
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_idx_o < IW'(N-1) || grant_idx_o == IW'(N-1)); // R2
  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && owner_req && !hold_done) |=> $stable(grant_idx_o)); // R7
  AST_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> $stable(grant_idx_o)); // R13
  AST_DROP_REARB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !owner_req && any_req) |=> (grant_idx_o == $past(win))); // R9

endmodule

// File: tb/sim_arb_slave_sel.sv
module sim_arb_slave_sel;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  req = '0;
  logic [7:0]  tr = '0;
  logic [7:0]  lv = '0;
  logic [15:0] ln = '0;
  logic        rdy = 1'b0;
  logic        auto_s = 1'b0;
  logic [1:0]  pol = '0;
  logic [1:0]  gran = '0;
  logic [3:0]  grant;
  logic [1:0]  gidx;

  int vectors = 0;
  int miscompares = 0;

  typedef struct { int idx; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  arb_slave_sel #(.N(N), .LW(2), .CW(4)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .trans_i(tr), .level_i(lv),
    .len_i(ln), .ready_i(rdy), .auto_i(auto_s), .policy_i(pol), .gran_i(gran),
    .grant_o(grant), .grant_idx_o(gidx)
  );

  task automatic compare(input int e, input string tag);
    vectors++;
    if (int'(gidx) != e || grant != (4'b1 << e)) begin
      miscompares++;
      $display("FAIL %s: idx=%0d grant=%b expected idx=%0d grant=%b",
               tag, gidx, grant, e, 4'b1 << e);
    end
  endtask

  // driver: inputs already set at a negedge; expectation applies after next posedge
  task automatic step(input int e, input string tag);
    exp_t x;
    x.idx = e;
    x.tag = tag;
    q.push_back(x);
    @(negedge clk);
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      compare(x.idx, x.tag);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(0, "R1 in reset");
    rst_ni = 1'b1;
    compare(0, "R1 after reset");

    // fixed priority, transfer granularity
    pol = 2'd0; gran = 2'd0; rdy = 1'b1;
    req = 4'b1110; tr = 8'h00;          step(1, "R3 lowest requester");
    tr = 8'h08; rdy = 1'b0;             step(1, "R14 ready low no beat");
    req = 4'b1100; tr = 8'h00; rdy = 1;  step(2, "R9 owner drops");
    req = 4'b1101; tr = 8'h20;          step(0, "R6 beat rearbitrates, R3");

    // rotating
    pol = 2'd1; req = 4'b1111; tr = 8'hFF;
    step(1, "R4 rotate to 1");
    step(2, "R4 rotate to 2");
    step(3, "R4 rotate to 3");
    step(0, "R4 wrap to 0");

    // level based, ties via rotating pointer
    pol = 2'd2; lv = 8'h3D;
    step(1, "R5 tie first");
    step(2, "R5 tie next");
    step(1, "R5 tie wrap");
    lv = 8'hC0;
    step(3, "R5 highest level");

    // transaction granularity
    pol = 2'd1; gran = 2'd1; lv = 8'h00;
    step(0, "R6 rotate after beat");
    tr = 8'h02; step(0, "R7 opening nonseq holds");
    tr = 8'h03; step(0, "R7 seq holds");
    tr = 8'h01; step(0, "R7 busy holds");
    tr = 8'h02; rdy = 1'b0; step(0, "R14 stalled nonseq holds");
    tr = 8'h00; rdy = 1'b1; step(1, "R7 idle ends transaction");

    // count granularity
    gran = 2'd2; ln = 16'h0300;
    req = 4'b1101; tr = 8'h00; step(2, "R9 drop, R8 load 3");
    tr = 8'hFF; step(2, "R8 beat 1 of 3");
    step(2, "R8 beat 2 of 3");
    step(3, "R8 beat 3 of 3 ends");
    req = 4'b0000; tr = 8'h00; step(3, "R13 park");
    step(3, "R13 park again");
    req = 4'b1001; step(0, "R4 from parked");
    tr = 8'hFF; step(3, "R8 zero length means one");

    // self-selecting
    auto_s = 1'b1; pol = 2'd1; gran = 2'd0;
    lv = 8'h55; ln = 16'h0000; req = 4'b0110; tr = 8'h00;
    step(1, "R10 equal levels rotate");
    tr = 8'hFF; step(1, "R11 no lengths means transaction");
    tr = 8'h00; lv = 8'h4D; step(1, "R10 differing levels pick highest");
    req = 4'b0100; ln = 16'h0200; step(2, "R11 nonzero length");
    req = 4'b0110; tr = 8'hFF; step(2, "R11 count 1 of 2");
    step(1, "R11 count ends, R10 level pick");

    // mode sampled only at arbitration points
    auto_s = 1'b0; pol = 2'd1; gran = 2'd1; ln = 16'h0000;
    req = 4'b0100; tr = 8'h00; step(2, "R9 drop to single");
    gran = 2'd0; req = 4'b0110; tr = 8'hFF; step(2, "R12 mid-hold change ignored");
    tr = 8'h00; step(1, "R7 idle ends, R12 new mode");
    tr = 8'hFF; step(2, "R12 transfer mode now active");

    // reset restarts pointer
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    compare(0, "R1 reset parks on 0");
    req = 4'b1111; tr = 8'h00; pol = 2'd1; gran = 2'd0;
    step(0, "R1 pointer cleared");

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule